// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped, tagged table that maps a fetch address to a predicted next address. Fetch looks it up with the current PC before the instruction is decoded. On a hit, fetch jumps to the stored target. On a miss, it moves on to the next sequential word, PC+4. Because the full upper PC is compared as a tag, instructions that are not branches are never found in the table. They fall through to PC+4 with no decode at all. A register-based jump whose target was recorded earlier is redirected in the same way as a direct branch.

Entries only change after a branch has resolved in the execute stage. A resolved taken branch or jump writes its target into its slot and displaces whatever was there before. A resolved not-taken branch that currently owns its slot removes that entry. With each resolved branch, execute also returns the next PC that fetch actually used. The block compares that value with the true outcome and raises a mispredict flag with the corrected address, so that the pipeline can squash the wrong-path instructions.

Top module: `btb_top`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is invalid, so every fetch lookup misses until a taken branch is installed.
- R2: On a lookup miss, `fetch_hit` is 0 and `fetch_next_pc` equals `fetch_pc + 4` in the same cycle.
- R3: After a resolve with `rslv_valid=1` and `rslv_taken=1`, a lookup of that same PC from the next cycle onward gives `fetch_hit=1` and `fetch_next_pc` equal to the resolved target. This holds for direct branches and for indirect jumps alike.
- R4: The slot is selected by PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). A hit also needs the valid bit set and the stored tag, PC bits [PC_W-1:IDX_W+2], equal to those of the fetch PC. A PC that shares the slot but not the tag misses.
- R5: A taken resolve replaces the entry already held in its slot. The old PC then misses, and the new PC hits with the new target.
- R6: A not-taken resolve whose PC hits in the table invalidates that entry. From the next cycle, that PC misses.
- R7: A not-taken resolve whose PC does not match the occupant of its slot leaves that occupant unchanged.
- R8: The true next PC is `rslv_target` when taken and `rslv_pc + 4` when not taken. In the same cycle, `rslv_fix_pc` shows the true next PC, and `rslv_mispredict` is 1 exactly when `rslv_valid=1` and the true next PC differs from `rslv_used_pc`.
- R9: When `rslv_valid` is 0, the table is not modified, whatever the other resolve inputs are.
- R10: A lookup in the same cycle as a write sees the table contents from before that clock edge. The write becomes visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_hit | output | 1 | Lookup found a valid entry with a matching tag |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| rslv_valid | input | 1 | A resolved branch is presented this cycle |
| rslv_pc | input | PC_W | Address of the resolved branch |
| rslv_taken | input | 1 | Resolved direction, 1 = taken |
| rslv_target | input | PC_W | Resolved target address |
| rslv_used_pc | input | PC_W | Next PC that fetch followed after this branch |
| rslv_mispredict | output | 1 | Fetch followed the wrong path |
| rslv_fix_pc | output | PC_W | Correct next PC for this branch |

## Verification
The assertions assume that every PC on both ports is word-aligned, because the two lowest bits take part in neither the index nor the tag. They also assume that `rslv_used_pc` is the address fetch really emitted, and that the resolve inputs carry meaning only while `rslv_valid` is high. The stimulus uses only aligned addresses. It pulses `rslv_valid` for one cycle per resolve and gives the used PC from its own model of what fetch would have done, including deliberately wrong values. It chooses address pairs that collide in one slot with different tags, and one address in the highest slot.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Slot number: word address modulo the table size.
  function automatic logic [63:0] slot_of(input logic [63:0] pc, input int idx_w);
    return (pc >> 2) & ((64'd1 << idx_w) - 64'd1);
  endfunction

  // Tag: every address bit above the slot bits.
  function automatic logic [63:0] tag_of(input logic [63:0] pc, input int idx_w);
    return pc >> (idx_w + 2);
  endfunction

  // Sequential successor of a word-aligned instruction.
  function automatic logic [63:0] seq_of(input logic [63:0] pc);
    return pc + 64'd4;
  endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int PC_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_vld,
  output logic [TAG_W-1:0] chk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] inv_sel;

  // One write strobe and one clear strobe for each slot.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign wr_sel[i]  = wr_en  && (wr_idx  == IDX_W'(i));
    assign inv_sel[i] = inv_en && (inv_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (wr_sel[i]) begin
        tag_q[i] <= wr_tag;
        tgt_q[i] <= wr_tgt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= (vld_q | wr_sel) & ~(inv_sel & ~wr_sel);
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_tgt  = tgt_q[rd_idx];
  assign chk_vld = vld_q[chk_idx];
  assign chk_tag = tag_q[chk_idx];

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (vld_q == '0));
  p_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))
              && (tgt_q[$past(wr_idx)] == $past(wr_tgt)));
  p_inv_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_q[$past(inv_idx)]);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inv_en) |=> $stable(vld_q));
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rslv_valid,
  input  logic [PC_W-1:0]  rslv_pc,
  input  logic             rslv_taken,
  input  logic [PC_W-1:0]  rslv_target,
  input  logic [PC_W-1:0]  rslv_used_pc,
  input  logic             chk_vld,
  input  logic [TAG_W-1:0] chk_tag,
  output logic [IDX_W-1:0] slot,
  output logic [TAG_W-1:0] tag,
  output logic             wr_en,
  output logic             inv_en,
  output logic             mispredict,
  output logic [PC_W-1:0]  fix_pc
);
  logic            own_hit;
  logic [PC_W-1:0] seq_pc;

  assign slot    = IDX_W'(btb_pkg::slot_of(64'(rslv_pc), IDX_W));
  assign tag     = TAG_W'(btb_pkg::tag_of(64'(rslv_pc), IDX_W));
  assign seq_pc  = PC_W'(btb_pkg::seq_of(64'(rslv_pc)));
  assign own_hit = chk_vld && (chk_tag == tag);

  assign wr_en      = rslv_valid && rslv_taken;
  assign inv_en     = rslv_valid && !rslv_taken && own_hit;
  assign fix_pc     = rslv_taken ? rslv_target : seq_pc;
  assign mispredict = rslv_valid && (fix_pc != rslv_used_pc);

  p_fix_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && !rslv_taken) |-> (fix_pc == rslv_pc + PC_W'(4)));
  p_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && !mispredict) |-> (rslv_used_pc == fix_pc));
  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, inv_en}));
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rslv_valid |-> (!wr_en && !inv_en && !mispredict));
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            rslv_valid,
  input  logic [PC_W-1:0] rslv_pc,
  input  logic            rslv_taken,
  input  logic [PC_W-1:0] rslv_target,
  input  logic [PC_W-1:0] rslv_used_pc,
  output logic            rslv_mispredict,
  output logic [PC_W-1:0] rslv_fix_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] f_slot, r_slot;
  logic [TAG_W-1:0] f_tag, r_tag;
  logic             rd_vld, chk_vld;
  logic [TAG_W-1:0] rd_tag, chk_tag;
  logic [PC_W-1:0]  rd_tgt;
  logic             wr_en, inv_en;

  assign f_slot = IDX_W'(btb_pkg::slot_of(64'(fetch_pc), IDX_W));
  assign f_tag  = TAG_W'(btb_pkg::tag_of(64'(fetch_pc), IDX_W));

  btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_slot), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
    .chk_idx(r_slot), .chk_vld(chk_vld), .chk_tag(chk_tag),
    .wr_en(wr_en), .wr_idx(r_slot), .wr_tag(r_tag), .wr_tgt(rslv_target),
    .inv_en(inv_en), .inv_idx(r_slot)
  );

  btb_resolve #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .rslv_valid(rslv_valid), .rslv_pc(rslv_pc), .rslv_taken(rslv_taken),
    .rslv_target(rslv_target), .rslv_used_pc(rslv_used_pc),
    .chk_vld(chk_vld), .chk_tag(chk_tag),
    .slot(r_slot), .tag(r_tag), .wr_en(wr_en), .inv_en(inv_en),
    .mispredict(rslv_mispredict), .fix_pc(rslv_fix_pc)
  );

  assign fetch_hit     = rd_vld && (rd_tag == f_tag);
  assign fetch_next_pc = fetch_hit ? rd_tgt : PC_W'(btb_pkg::seq_of(64'(fetch_pc)));

  p_hit_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> (fetch_next_pc == rd_tgt));
  p_miss_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_hit |-> (fetch_next_pc == fetch_pc + PC_W'(4)));
  p_tag_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tag != f_tag) |-> !fetch_hit);
endmodule

// File: tb/tb_btb_top.sv
module tb_btb_top;
  localparam int PC_W = 32;
  localparam int VW   = 1 + 32 + 1 + 32 + 32 + 32 + 1 + 32;
  localparam int NV   = 9;
  // Fields: res_valid, res_pc, taken, target, used_pc, fetch_pc, exp_hit, exp_next
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 32'h0, 1'b0, 32'h0, 32'h0,            32'h1000, 1'b0, 32'h1004}, // R2 miss
    {1'b1, 32'h1000, 1'b1, 32'h2000, 32'h1004,   32'h1000, 1'b1, 32'h2000}, // R3 install
    {1'b0, 32'h0, 1'b0, 32'h0, 32'h0,            32'h1040, 1'b0, 32'h1044}, // R4 alias
    {1'b1, 32'h1040, 1'b0, 32'h0, 32'h1044,      32'h1000, 1'b1, 32'h2000}, // R7 keep
    {1'b1, 32'h1040, 1'b1, 32'h3000, 32'h1044,   32'h1000, 1'b0, 32'h1004}, // R5 replace
    {1'b0, 32'h0, 1'b0, 32'h0, 32'h0,            32'h1040, 1'b1, 32'h3000}, // R5 new hit
    {1'b1, 32'h1040, 1'b0, 32'h0, 32'h3000,      32'h1040, 1'b0, 32'h1044}, // R6 invalidate
    {1'b1, 32'h2ffc, 1'b1, 32'h0100, 32'h0100,   32'h2ffc, 1'b1, 32'h0100}, // R3 jump, top slot
    {1'b0, 32'h2ffc, 1'b0, 32'h0, 32'h0,         32'h2ffc, 1'b1, 32'h0100}  // R9 no write
  };

  logic            clk = 0;
  logic            rst_n = 0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            fetch_hit;
  logic [PC_W-1:0] fetch_next_pc;
  logic            rslv_valid = 0;
  logic [PC_W-1:0] rslv_pc = '0;
  logic            rslv_taken = 0;
  logic [PC_W-1:0] rslv_target = '0;
  logic [PC_W-1:0] rslv_used_pc = '0;
  logic            rslv_mispredict;
  logic [PC_W-1:0] rslv_fix_pc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btb_top #(.ENTRIES(16), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .fetch_next_pc(fetch_next_pc), .rslv_valid(rslv_valid), .rslv_pc(rslv_pc),
    .rslv_taken(rslv_taken), .rslv_target(rslv_target), .rslv_used_pc(rslv_used_pc),
    .rslv_mispredict(rslv_mispredict), .rslv_fix_pc(rslv_fix_pc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input string req, input logic [31:0] pc, input bit hit);
    fetch_pc = pc;
    #1;
    chk(req, 64'(fetch_hit), 64'(hit));
    chk(req, 64'(fetch_next_pc), 64'(hit ? fetch_next_pc : pc + 32'd4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: lookups miss while reset is held
    lookup("R1", 32'h1000, 0);
    lookup("R1", 32'h2ffc, 0);
    rst_n = 1;
    @(negedge clk);
    lookup("R1", 32'h0040, 0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      logic [31:0] truth;
      e = VEC[v];
      @(negedge clk);
      rslv_valid   = e[162];
      rslv_pc      = e[161:130];
      rslv_taken   = e[129];
      rslv_target  = e[128:97];
      rslv_used_pc = e[96:65];
      #1;
      truth = e[129] ? e[128:97] : e[161:130] + 32'd4;
      // R8: mispredict and corrected PC, same cycle
      chk("R8", 64'(rslv_mispredict), 64'(e[162] && (truth != e[96:65])));
      if (e[162]) chk("R8", 64'(rslv_fix_pc), 64'(truth));
      @(negedge clk);
      rslv_valid = 0;
      fetch_pc = e[64:33];
      #1;
      chk($sformatf("R3/R4/R5/R6/R7/R9 vec%0d hit", v), 64'(fetch_hit), 64'(e[32]));
      chk($sformatf("R2/R3 vec%0d next", v), 64'(fetch_next_pc), 64'(e[31:0]));
    end

    // R10: write and lookup of the same PC in one cycle
    @(negedge clk);
    rslv_valid = 1; rslv_pc = 32'h1080; rslv_taken = 1;
    rslv_target = 32'h4000; rslv_used_pc = 32'h4000;
    fetch_pc = 32'h1080;
    #1;
    chk("R10 before edge", 64'(fetch_hit), 64'd0);
    chk("R10 before edge", 64'(fetch_next_pc), 64'h1084);
    @(negedge clk);
    rslv_valid = 0;
    #1;
    chk("R10 after edge", 64'(fetch_hit), 64'd1);
    chk("R10 after edge", 64'(fetch_next_pc), 64'h4000);

    // R9: a not-taken resolve with valid low does not invalidate
    @(negedge clk);
    rslv_valid = 0; rslv_pc = 32'h1080; rslv_taken = 0;
    @(negedge clk);
    lookup("R9", 32'h1080, 1);

    // R1: a reset in mid-run clears installed entries
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    lookup("R1 mid-run", 32'h1080, 0);
    lookup("R1 mid-run", 32'h2ffc, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule